// File: doc/BRIEF.md
# Serial Keyboard Byte Receiver with Read-Pop Queue

The block takes the two open-collector lines of a PS/2 keyboard port, clock and data, and brings both into the system clock domain through a short synchroniser chain. It shifts in one data bit on each falling edge of the synchronised keyboard clock. An 11-bit frame is accepted only if three conditions hold: the start bit is 0, the parity over the data bits is odd, and the stop bit is 1. Each accepted byte is stored unchanged in a small circular queue, including prefix bytes such as 0xE0 and 0xF0. Decoding those prefixes is left to software.

A processor reads the block through a simple read port. A read with `rd_word` low returns a status word whose bit 0 is set while the queue holds at least one byte. A read with `rd_word` high returns the oldest byte and removes it from the queue. Read data is combinational from the current queue state. The removal takes effect on the clock edge on which `rd_stb` is sampled high.

Top module: `kbd_rx_queue`

## Requirements
- R1: After reset the queue is empty, so a status read returns 32'h0000_0000.
- R2: A frame is accepted when its start bit is 0, its eight data bits (sent LSB first) plus the parity bit hold an odd number of ones, and its stop bit is 1. Bits are sampled on falling edges of `ps2_clk_i`. The accepted byte is queued within 3 clock cycles after the falling edge of `ps2_clk_i` for the stop bit.
- R3: A frame whose parity bit makes the count of ones even is discarded.
- R4: A frame whose start bit is 1, or whose stop bit is 0, is discarded.
- R5: A data read (`rd_stb`=1, `rd_word`=1) on a non-empty queue returns the oldest byte in bits 7:0, with bits 31:8 zero. The byte is removed on that clock edge.
- R6: The queue holds DEPTH (16) bytes in arrival order. A byte that arrives while the queue is full is dropped, and the stored bytes are kept.
- R7: A status read (`rd_stb`=1, `rd_word`=0) returns the not-empty flag in bit 0, with the other bits zero. It removes nothing.
- R8: A data read on an empty queue returns 32'h0 and changes nothing.
- R9: When a byte is accepted on the same edge as a data-read pop, both take effect and the stored count is unchanged.
- R10: Byte values are stored unaltered, including 0xE0 and 0xF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_i | input | 1 | Keyboard clock line, asynchronous |
| ps2_dat_i | input | 1 | Keyboard data line, asynchronous |
| rd_stb | input | 1 | Read strobe; with `rd_word`=1 it pops the queue |
| rd_word | input | 1 | 0 selects the status word, 1 selects the data word |
| rd_data | output | 32 | Read data for the selected word |

## Verification
A falling edge on `ps2_clk_i` passes through two synchroniser flops and an edge-detect flop. The stop bit's byte is therefore written on the third rising clock edge after that falling edge, and the status bit reflects it from then on. The bench waits several cycles after each frame before it reads the status.

Read data is sampled one nanosecond after the strobe is set at a falling clock edge. The pop is then taken at the next rising edge, and its effect is checked by a later read.

For the simultaneous push-and-pop case, the bench counts exactly two rising edges after the stop-bit falling edge. It then holds the pop strobe across the third edge, which is the edge that writes the byte, so that both happen together.

// File: rtl/kbd_rx_queue.sv
module kbd_rx_queue #(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ps2_clk_i,
  input  logic        ps2_dat_i,
  input  logic        rd_stb,
  input  logic        rd_word,
  output logic [31:0] rd_data
);
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int LAST_BIT = 10;

  logic [SYNC_STAGES-1:0] kc_sync, kd_sync;
  logic                   kc_prev;
  logic [3:0]             bit_idx;
  logic [9:0]             shreg;
  logic [7:0]             mem [DEPTH];
  logic [AW-1:0]          wr_ptr, rd_ptr;
  logic [CW-1:0]          count;

  wire kc_s     = kc_sync[SYNC_STAGES-1];
  wire kd_s     = kd_sync[SYNC_STAGES-1];
  wire fall     = kc_prev & ~kc_s;
  wire frame_ok = fall && bit_idx == 4'(LAST_BIT) && !shreg[0] && (^shreg[9:1]) && kd_s;
  wire empty    = (count == '0);
  wire full     = (count == CW'(DEPTH));
  wire push     = frame_ok && !full;
  wire pop      = rd_stb && rd_word && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kc_sync <= '1;
      kd_sync <= '1;
      kc_prev <= 1'b1;
    end else begin
      kc_sync <= {kc_sync[SYNC_STAGES-2:0], ps2_clk_i};
      kd_sync <= {kd_sync[SYNC_STAGES-2:0], ps2_dat_i};
      kc_prev <= kc_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx <= '0;
      shreg   <= '0;
    end else if (fall) begin
      if (bit_idx == 4'(LAST_BIT)) begin
        bit_idx <= '0;
      end else begin
        shreg   <= {kd_s, shreg[9:1]};
        bit_idx <= bit_idx + 4'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= shreg[8:1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = rd_word ? (empty ? 32'h0 : {24'h0, mem[rd_ptr]})
                           : {31'h0, ~empty};

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && frame_ok && !(rd_stb && rd_word)) |=> full && $stable(wr_ptr));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !full && !(rd_stb && rd_word)) |=> count == $past(count) + 1'b1);

  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_stb && rd_word && !frame_ok) |=> empty && $stable(rd_ptr));

  p_status_nopop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_word) |=> $stable(rd_ptr));

  p_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !full && rd_stb && rd_word && !empty) |=> $stable(count));
endmodule

// File: tb/test_kbd_rx_queue.sv
module test_kbd_rx_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ps2_clk_i = 1'b1;
  logic        ps2_dat_i = 1'b1;
  logic        rd_stb = 1'b0;
  logic        rd_word = 1'b0;
  logic [31:0] rd_data;

  int total = 0;
  int bad = 0;
  localparam int HALF = 8;

  always #5 clk = ~clk;

  kbd_rx_queue i_kbd_rx_queue (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk_i), .ps2_dat_i(ps2_dat_i),
    .rd_stb(rd_stb), .rd_word(rd_word), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic w, output logic [31:0] v);
    @(negedge clk);
    rd_word = w;
    rd_stb  = 1'b1;
    #1 v = rd_data;
    @(posedge clk);
    #1 rd_stb = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic st, input logic flip_par,
                      input logic sp, input logic ovl, input logic [7:0] ovl_exp);
    logic [10:0] bits;
    logic [31:0] v;
    bits = {sp, ~(^b) ^ flip_par, b, st};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      ps2_dat_i = bits[i];
      idle(HALF);
      ps2_clk_i = 1'b0;
      if (ovl && i == 10) begin
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rd_word = 1'b1;
        rd_stb  = 1'b1;
        #1 v = rd_data;
        check("R9 pop during push", v, {24'h0, ovl_exp});
        @(posedge clk);
        #1 rd_stb = 1'b0;
        idle(HALF - 3);
      end else begin
        idle(HALF);
      end
      ps2_clk_i = 1'b1;
    end
    @(negedge clk);
    ps2_dat_i = 1'b1;
    idle(5);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    do_read(1'b0, v);
    check("R1 reset status", v, 32'h0);
  endtask

  task automatic t_empty_read;
    logic [31:0] v;
    do_read(1'b1, v);
    check("R8 empty data read", v, 32'h0);
    do_read(1'b0, v);
    check("R8 still empty", v, 32'h0);
  endtask

  task automatic t_single;
    logic [31:0] v;
    send(8'h1C, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0);
    do_read(1'b0, v);
    check("R2 status after frame", v, 32'h1);
    do_read(1'b0, v);
    check("R7 status read does not pop", v, 32'h1);
    do_read(1'b1, v);
    check("R5 data byte", v, 32'h0000_001C);
    do_read(1'b0, v);
    check("R5 popped to empty", v, 32'h0);
  endtask

  task automatic t_bad_frames;
    logic [31:0] v;
    send(8'h33, 1'b0, 1'b1, 1'b1, 1'b0, 8'h0);
    do_read(1'b0, v);
    check("R3 bad parity dropped", v, 32'h0);
    send(8'h44, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0);
    do_read(1'b0, v);
    check("R4 bad start dropped", v, 32'h0);
    send(8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
    do_read(1'b0, v);
    check("R4 bad stop dropped", v, 32'h0);
  endtask

  task automatic t_prefixes;
    logic [31:0] v;
    send(8'hE0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0);
    send(8'hF0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0);
    send(8'h5A, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0);
    do_read(1'b1, v);
    check("R10 first E0", v, 32'hE0);
    do_read(1'b1, v);
    check("R10 second F0", v, 32'hF0);
    do_read(1'b1, v);
    check("R6 order third", v, 32'h5A);
    do_read(1'b0, v);
    check("R6 drained", v, 32'h0);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    for (int i = 0; i < 17; i++)
      send(8'(i * 7 + 3), 1'b0, 1'b0, 1'b1, 1'b0, 8'h0);
    for (int i = 0; i < 16; i++) begin
      do_read(1'b1, v);
      check("R6 full queue content", v, {24'h0, 8'(i * 7 + 3)});
    end
    do_read(1'b0, v);
    check("R6 seventeenth dropped", v, 32'h0);
  endtask

  task automatic t_simultaneous;
    logic [31:0] v;
    send(8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0);
    send(8'h22, 1'b0, 1'b0, 1'b1, 1'b1, 8'h11);
    do_read(1'b0, v);
    check("R9 count kept", v, 32'h1);
    do_read(1'b1, v);
    check("R9 new byte kept", v, 32'h22);
    do_read(1'b0, v);
    check("R9 empty after", v, 32'h0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_empty_read();
    t_single();
    t_bad_frames();
    t_prefixes();
    t_overflow();
    t_simultaneous();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule